// File: doc/BRIEF.md
# Symbol Group Serializer with Amplifier Ramp

This block sits in a transmitter data path between an already encoded symbol stream and the power amplifier. The host loads a timing control word and then writes groups of up to eight symbols, one group per data write. The block sends each group out one symbol at a time. It paces the symbols with a clock enable that it divides down from the system clock.

Before the first symbol of a burst, the block raises a 3-bit amplifier level in eight equal steps. After the last symbol, it lowers the level again in eight steps. The step length is the serializer divide multiplied by a separate edge divide. A one-entry holding buffer with a busy flag lets the host queue the next group while the current one is still being sent. Groups that follow each other therefore leave the block with no gap. Each group carries its own symbol count, so a short tail group can follow full-length groups.

Top module: `symgrp_ser`

## Requirements
- R1: Writing with `sel_i`=0 loads the 8-bit timing word, and `rd_data_o` always returns it. The word resets to 0. Its fields are: bits 7:5 width code, bits 4:3 edge code, bits 2:0 divide code.
- R2: While symbols are sent, each symbol stays on `sym_o` for exactly D = divide code + 1 system cycles.
- R3: A group contains width code + 1 symbols. Width code 0 is clamped to 2 symbols.
- R4: Writing with `sel_i`=1 supplies the symbols of a group in `wdata_i`. Bit 0 is sent first, then the higher bits in order.
- R5: The width code is captured at the data write. A group queued during a transmission follows the previous group's last symbol with no idle cycle, even when its width code differs.
- R6: A burst starts with a rise on `ramp_o`. The rise passes through levels 0 to 7, and each level lasts P = D × (edge code + 1) cycles. The first symbol appears 8P cycles after the rise begins.
- R7: After the last symbol of a burst, `ramp_o` stays at 7 for P cycles. It then steps down through 6 to 0, one level every P cycles, and reaches 0 exactly 7P cycles after the last symbol ends.
- R8: `busy_o` is high while the holding buffer is full. It drops when the group moves into the shifter. A data write made while `busy_o` is high is ignored.
- R9: `sym_o` resets to 0. When no group is being sent, `sym_o` holds the last symbol sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| sel_i | input | 1 | Register select: 0 timing word, 1 symbol data |
| wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Timing word read-back |
| busy_o | output | 1 | Holding buffer full |
| sym_o | output | 1 | Serial symbol output |
| ramp_o | output | 3 | Amplifier level |

## Verification
The assertions check properties that must hold on every cycle:
- `ramp_o` moves by at most one level per cycle.
- `sym_o` changes only while the amplifier level is at full scale.
- `busy_o` rises only on a data write and falls only at full level.
- The timing word read-back follows each register write.

Exact step lengths, symbol periods, bit order, group lengths, the clamp on width code 0, gapless chaining and the ignored write while busy are shown only by the bench. The bench records bursts over every divide and edge code and compares each recorded trace with cycle positions it derives itself.

// File: rtl/symgrp_pkg.sv
package symgrp_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned WID_W  = 3;
  localparam int unsigned EDG_W  = 2;
  localparam int unsigned DIV_W  = 3;
  localparam int unsigned LVL_W  = 3;
  localparam int unsigned CNT_W  = $clog2(DATA_W) + 1;

  typedef struct packed {
    logic [WID_W-1:0] width;
    logic [EDG_W-1:0] edg;
    logic [DIV_W-1:0] div;
  } tctl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UP   = 2'd1,
    ST_SEND = 2'd2,
    ST_DN   = 2'd3
  } ser_state_e;

  function automatic logic [CNT_W-1:0] grp_len(input logic [WID_W-1:0] code);
    if (code == '0) grp_len = CNT_W'(2);
    else            grp_len = CNT_W'(code) + CNT_W'(1);
  endfunction
endpackage

// File: rtl/symgrp_ctrl_reg.sv
module symgrp_ctrl_reg
  import symgrp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output tctl_t             ctl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_o <= '0;
    else if (wr_i) ctl_o <= tctl_t'(wdata_i);
  end
endmodule

// File: rtl/symgrp_tick_div.sv
module symgrp_tick_div #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] lim_i,
  input  logic         en_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/symgrp_shifter.sv
module symgrp_shifter
  import symgrp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] ldata_i,
  input  logic [WID_W-1:0]  lwidth_i,
  input  logic              tick_i,
  input  logic              step_i,
  output logic              busy_o,
  output logic              sym_o,
  output logic [LVL_W-1:0]  ramp_o,
  output logic              div_clr_o,
  output logic              step_clr_o
);
  localparam logic [LVL_W-1:0] LVL_TOP = '1;

  ser_state_e        st_q;
  logic [LVL_W-1:0]  stp_q;
  logic [DATA_W-1:0] buf_q, sh_q;
  logic [CNT_W-1:0]  buf_n_q, rem_q;
  logic              full_q, sym_q;
  logic              take, accept, grp_done;

  assign accept   = load_i && !full_q;
  assign grp_done = (st_q == ST_SEND) && tick_i && (rem_q == '0);
  assign take     = ((st_q == ST_UP) && step_i && (stp_q == LVL_TOP)) ||
                    (grp_done && full_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q  <= 1'b0;
      buf_q   <= '0;
      buf_n_q <= '0;
    end else if (accept) begin
      full_q  <= 1'b1;
      buf_q   <= ldata_i;
      buf_n_q <= grp_len(lwidth_i);
    end else if (take) begin
      full_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q <= 1'b0;
      sh_q  <= '0;
      rem_q <= '0;
    end else if (take) begin
      sym_q <= buf_q[0];
      sh_q  <= buf_q >> 1;
      rem_q <= buf_n_q - CNT_W'(1);
    end else if ((st_q == ST_SEND) && tick_i && (rem_q != '0)) begin
      sym_q <= sh_q[0];
      sh_q  <= sh_q >> 1;
      rem_q <= rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      stp_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          stp_q <= '0;
          if (full_q) st_q <= ST_UP;
        end
        ST_UP: if (step_i) begin
          if (stp_q == LVL_TOP) begin
            st_q  <= ST_SEND;
            stp_q <= '0;
          end else begin
            stp_q <= stp_q + LVL_W'(1);
          end
        end
        ST_SEND: if (grp_done && !full_q) begin
          st_q  <= ST_DN;
          stp_q <= '0;
        end
        ST_DN: if (step_i) begin
          if (stp_q == LVL_TOP) begin
            st_q  <= ST_IDLE;
            stp_q <= '0;
          end else begin
            stp_q <= stp_q + LVL_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_UP:   ramp_o = stp_q;
      ST_SEND: ramp_o = LVL_TOP;
      ST_DN:   ramp_o = LVL_TOP - stp_q;
      default: ramp_o = '0;
    endcase
  end

  // divider phase restarts with each burst; step counter restarts per edge
  assign div_clr_o  = (st_q == ST_IDLE);
  assign step_clr_o = (st_q == ST_IDLE) || (st_q == ST_SEND);
  assign busy_o     = full_q;
  assign sym_o      = sym_q;
endmodule

// File: rtl/symgrp_ser.sv
module symgrp_ser
  import symgrp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              sym_o,
  output logic [LVL_W-1:0]  ramp_o
);
  tctl_t ctl;
  logic  tick, step, div_clr, step_clr;

  symgrp_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en_i && !sel_i),
    .wdata_i (wdata_i),
    .ctl_o   (ctl)
  );

  symgrp_tick_div #(.W(DIV_W)) u_symdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (div_clr),
    .lim_i  (ctl.div),
    .en_i   (1'b1),
    .tick_o (tick)
  );

  // counts serializer ticks, so the step length is the product of both divides
  symgrp_tick_div #(.W(EDG_W)) u_edgediv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (step_clr),
    .lim_i  (ctl.edg),
    .en_i   (tick),
    .tick_o (step)
  );

  symgrp_shifter u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_en_i && sel_i),
    .ldata_i    (wdata_i),
    .lwidth_i   (ctl.width),
    .tick_i     (tick),
    .step_i     (step),
    .busy_o     (busy_o),
    .sym_o      (sym_o),
    .ramp_o     (ramp_o),
    .div_clr_o  (div_clr),
    .step_clr_o (step_clr)
  );

  assign rd_data_o = DATA_W'(ctl);
endmodule

// File: rtl/symgrp_ser_chk.sv
module symgrp_ser_chk
  import symgrp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              sel_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              busy_o,
  input logic              sym_o,
  input logic [LVL_W-1:0]  ramp_o
);
  // R1
  ctl_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !sel_i) |=> (rd_data_o == $past(wdata_i)));

  // R6
  ramp_slew_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ramp_o) |-> ((ramp_o == $past(ramp_o) + LVL_W'(1)) ||
                          ($past(ramp_o) == ramp_o + LVL_W'(1))));

  // R9
  sym_at_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sym_o) |-> (ramp_o == '1));

  // R8
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_en_i && sel_i));

  // R8
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (ramp_o == '1));
endmodule

bind symgrp_ser symgrp_ser_chk u_chk (.*);

// File: tb/symgrp_ser_test.sv
module symgrp_ser_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       sel_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rd_data_o;
  logic       busy_o, sym_o;
  logic [2:0] ramp_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  symgrp_ser uut (.*);

  always #10 clk_i = ~clk_i;

  localparam int TR = 2048;
  logic       tr_sym [TR];
  logic [2:0] tr_ramp[TR];
  logic       rec_on = 1'b0;
  int         tcnt = 0;

  always @(negedge clk_i) begin
    if (rec_on) begin
      if (tcnt < TR) begin
        tr_sym[tcnt]  <= sym_o;
        tr_ramp[tcnt] <= ramp_o;
      end
      tcnt <= tcnt + 1;
    end else begin
      tcnt <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    wr_en_i = 1'b1; sel_i = s; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic int glen(input logic [2:0] w);
    return (w == 3'd0) ? 2 : int'(w) + 1;
  endfunction

  logic [2:0] g_w  [3];
  logic [7:0] g_dat[3];

  task automatic run_burst(input int d, input int e, input int ng, input bit dup);
    int p, dd, n, t3, t4, t7, ts, te, k;
    logic ex[24];
    logic [7:0] c;
    dd = d + 1;
    p = dd * (e + 1);
    n = 0;
    for (int g = 0; g < ng; g++)
      for (int j = 0; j < glen(g_w[g]); j++) begin
        ex[n] = g_dat[g][j];
        n++;
      end
    rec_on = 1'b1;
    c = {g_w[0], 2'(e), 3'(d)};
    wr(1'b0, c);
    chk(rd_data_o == c, "R1 readback", rd_data_o, c);
    wr(1'b1, g_dat[0]);
    if (dup) begin
      chk(busy_o == 1'b1, "R8 busy after write", busy_o, 1);
      wr(1'b1, ~g_dat[0]);
    end
    for (int g = 1; g < ng; g++) begin
      while (busy_o) @(negedge clk_i);
      wr(1'b0, {g_w[g], 2'(e), 3'(d)});
      wr(1'b1, g_dat[g]);
    end
    repeat (16 * p + n * dd + 24) @(negedge clk_i);
    rec_on = 1'b0;
    @(negedge clk_i);
    t3 = -1; t4 = -1; t7 = -1;
    for (int i = 0; i < TR; i++) begin
      if (t3 < 0 && tr_ramp[i] == 3'd3) t3 = i;
      if (t4 < 0 && tr_ramp[i] == 3'd4) t4 = i;
      if (t7 < 0 && tr_ramp[i] == 3'd7) t7 = i;
    end
    chk(t3 >= 0 && t7 >= 0, "R6 ramp reaches top", t7, 1);
    if (t3 < 0 || t7 < 0) return;
    chk(t4 - t3 == p, "R6 step length", t4 - t3, p);
    chk(t7 - t3 == 4 * p, "R6 rise timing", t7 - t3, 4 * p);
    ts = t7 + p;
    for (int i = 0; i < n; i++) begin
      k = ts + i * dd;
      chk(tr_sym[k + dd / 2] == ex[i], "R4 symbol order", tr_sym[k + dd / 2], ex[i]);
      chk(tr_sym[k] == ex[i] && tr_sym[k + dd - 1] == ex[i], "R2 symbol period",
          tr_sym[k + dd - 1], ex[i]);
    end
    te = ts + n * dd;
    chk(tr_ramp[te - 1] == 3'd7 && tr_ramp[te + p - 1] == 3'd7, "R7 hold top",
        tr_ramp[te + p - 1], 7);
    chk(tr_ramp[te + p] == 3'd6, "R7 first fall step", tr_ramp[te + p], 6);
    chk(tr_ramp[te + 7 * p - 1] == 3'd1 && tr_ramp[te + 7 * p] == 3'd0,
        "R3 group length / R7 fall end", tr_ramp[te + 7 * p], 0);
    chk(tr_sym[te + 7 * p] == ex[n - 1], "R9 hold last symbol", tr_sym[te + 7 * p], ex[n - 1]);
    if (ng > 1)
      chk(tr_ramp[ts + glen(g_w[0]) * dd] == 3'd7, "R5 no gap between groups",
          tr_ramp[ts + glen(g_w[0]) * dd], 7);
    chk(busy_o == 1'b0, "R8 busy clear after burst", busy_o, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(rd_data_o == 8'h00, "R1 reset value", rd_data_o, 0);
    chk(busy_o == 1'b0, "R8 reset busy", busy_o, 0);
    chk(ramp_o == 3'd0, "R6 reset level", ramp_o, 0);
    chk(sym_o == 1'b0, "R9 reset symbol", sym_o, 0);

    // every divide and edge code
    for (int d = 0; d < 8; d++)
      for (int e = 0; e < 4; e++) begin
        g_w[0]   = 3'($urandom_range(1, 7));
        g_dat[0] = 8'($urandom);
        run_burst(d, e, 1, 1'b0);
      end

    // every width code, clamp at code 0 (R3)
    for (int w = 0; w < 8; w++) begin
      g_w[0]   = 3'(w);
      g_dat[0] = 8'hA5 ^ 8'(w);
      run_burst(1, 0, 1, 1'b0);
    end

    // chained groups with changing widths (R5)
    for (int r = 0; r < 6; r++) begin
      for (int g = 0; g < 3; g++) begin
        g_w[g]   = 3'($urandom_range(0, 7));
        g_dat[g] = 8'($urandom);
      end
      g_w[2] = 3'd1;
      run_burst($urandom_range(1, 7), $urandom_range(0, 3), 2 + (r % 2), 1'b0);
    end

    // write while busy is ignored (R8)
    g_w[0] = 3'd4; g_dat[0] = 8'h3C;
    run_burst(2, 1, 1, 1'b1);
    g_w[0] = 3'd7; g_dat[0] = 8'h96;
    run_burst(0, 0, 1, 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule